// File: doc/BRIEF.md
# Reset Pulse Generator with Pin Glitch Filter

This block is the reset controller of a chip. It takes a power-on request and a brown-out request from the supply monitors, plus the sensed level of a shared active-low reset pin. Any of these sources starts a minimum-length reset pulse. While the pulse runs, the block pulls the pin low through an open-drain enable, so the rest of the board sees the reset too. It also holds the internal system reset low. The internal reset is asserted at once by the supply requests. It is released synchronously a few clocks after the pulse ends.

The pin is sensed through a synchronizer and a run-length filter. Short low glitches are dropped, and a sustained low starts a pulse. While the block drives the pin itself, and for the synchronizer depth after it lets go, the sensed pin is masked. This stops the block from retriggering on its own output. A request that arrives while a pulse runs reloads the timer to its full length. A one-hot cause register records the source of the latest request until software-side logic clears it.

All lengths are given in clock cycles. The defaults assume a 16 MHz reference: `PULSE_CYC` = 320 gives 20 us, and `FILT_CYC` = 3 places the filter threshold between 100 ns and 300 ns. The block has no data stream, so it has no valid/ready handshake. Every pin is plain control or status.

Top module: `reset_pulse_ctrl`

## Requirements
- R1: While `por_req` is high, `pin_drive_low` is 1, `sys_rst_n` is 0 and `cause` is 3'b001, with no clock edge needed.
- R2: After `por_req` falls, `pin_drive_low` falls on the PULSE_CYC-th rising clock edge.
- R3: `bor_req` high drives `sys_rst_n` low at once. The first rising edge that samples `bor_req` high is edge 1. `pin_drive_low` rises after edge SYNC_STAGES+1 and falls on edge PULSE_CYC+SYNC_STAGES after the last edge that sampled `bor_req` high.
- R4: Consider a run of consecutive rising edges that sample `pin_in` low, with the first of them as edge 1. A run shorter than FILT_CYC edges is ignored. A run of FILT_CYC edges starts a pulse of PULSE_CYC cycles, with `pin_drive_low` rising after edge FILT_CYC+SYNC_STAGES. The internal pin request lasts one cycle.
- R5: A request during an active pulse reloads the timer to PULSE_CYC, so the pulse ends at the full length after the newest request.
- R6: `sys_rst_n` rises on the SYNC_STAGES-th rising edge after the edge that drops `pin_drive_low`, and only on a clock edge.
- R7: `sys_rst_n` is never high in the cycle where `pin_drive_low` falls.
- R8: `cause` is one-hot or zero: bit 0 is power-on, bit 1 is brown-out, bit 2 is pin. The latest request sets its bit and clears the others. `cause_clr` sampled high zeroes the register. A request in the same cycle wins over the clear.
- R9: The block's own low drive on the pin, and the SYNC_STAGES cycles after it stops, never count as an external pin reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_req | input | 1 | Power-on request, active high, asynchronous; also resets the block |
| bor_req | input | 1 | Brown-out request, active high, asynchronous |
| pin_in | input | 1 | Sensed level of the shared reset pin, active low |
| cause_clr | input | 1 | Synchronous clear of the cause register |
| pin_drive_low | output | 1 | Open-drain enable: 1 pulls the reset pin low |
| sys_rst_n | output | 1 | Internal system reset, active low |
| cause | output | 3 | One-hot source of the latest reset request |

## Verification
The bound checker watches these rules on every clock:
- the forced state during power-on;
- the full reload of the timer on each request;
- the one-cycle pin request;
- that the internal reset stays low when the pin drive drops;
- the one-hot form of the cause register;
- that no pin request follows the end of the block's own drive.

Other behaviour only shows in the bench's scenarios:
- exact pulse lengths for each source;
- the filter threshold on each side of FILT_CYC;
- the restart when a brown-out arrives during a pin-started pulse;
- the release delay of the internal reset;
- a request winning over a clear in the same cycle.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int CAUSE_W   = 3;
  localparam int CAUSE_POR = 0;
  localparam int CAUSE_BOR = 1;
  localparam int CAUSE_PIN = 2;
  typedef logic [CAUSE_W-1:0] cause_t;
  localparam cause_t CAUSE_NONE = '0;
endpackage

// File: rtl/rstc_sync.sv
// Multi-stage synchronizer with asynchronous preset/clear to RST_VAL.
module rstc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] taps;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) taps <= {STAGES{RST_VAL}};
    else      taps <= {taps[STAGES-2:0], d};
  end

  assign q = taps[STAGES-1];
endmodule

// File: rtl/rstc_pin_filter.sv
// Synchronizes the reset pin, masks the block's own drive and qualifies
// a low run of FILT_CYC sampled cycles into a single-cycle request.
module rstc_pin_filter #(
  parameter int FILT_CYC    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  input  logic pin_in,
  input  logic self_drive,
  output logic pin_req
);
  localparam int FW = $clog2(FILT_CYC + 1);

  logic                   pin_s;
  logic [SYNC_STAGES-1:0] drv_dly;
  logic                   mask;
  logic                   low_seen;
  logic [FW-1:0]          low_cnt;

  rstc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .arst(arst),
    .d   (pin_in),
    .q   (pin_s)
  );

  // Own drive echoes through the synchronizer for SYNC_STAGES cycles.
  always_ff @(posedge clk or posedge arst) begin
    if (arst) drv_dly <= '1;
    else      drv_dly <= {drv_dly[SYNC_STAGES-2:0], self_drive};
  end

  assign mask     = self_drive | (|drv_dly);
  assign low_seen = ~pin_s & ~mask;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)                            low_cnt <= '0;
    else if (!low_seen)                  low_cnt <= '0;
    else if (low_cnt != FW'(FILT_CYC))   low_cnt <= low_cnt + 1'b1;
  end

  assign pin_req = low_seen && (low_cnt == FW'(FILT_CYC - 1));
endmodule

// File: rtl/rstc_pulse_timer.sv
// Down-counter that loads the full pulse length on any request.
module rstc_pulse_timer #(
  parameter int PULSE_CYC = 320,
  parameter int CW        = $clog2(PULSE_CYC + 1)
) (
  input  logic          clk,
  input  logic          arst,
  input  logic          load,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or posedge arst) begin
    if (arst)            cnt <= CW'(PULSE_CYC);
    else if (load)       cnt <= CW'(PULSE_CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/reset_pulse_ctrl.sv
module reset_pulse_ctrl
  import rstc_pkg::*;
#(
  parameter int PULSE_CYC   = 320,
  parameter int FILT_CYC    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               por_req,
  input  logic               bor_req,
  input  logic               pin_in,
  input  logic               cause_clr,
  output logic               pin_drive_low,
  output logic               sys_rst_n,
  output logic [CAUSE_W-1:0] cause
);
  localparam int CW = $clog2(PULSE_CYC + 1);

  logic [SYNC_STAGES-1:0] bor_taps;
  logic                   bor_load;
  logic                   bor_hold;
  logic                   pin_req;
  logic                   tmr_load;
  logic [CW-1:0]          tmr_cnt;
  logic                   active;
  logic                   out_arst;
  cause_t                 cause_q;

  // Brown-out request into the clock domain.
  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) bor_taps <= '0;
    else         bor_taps <= {bor_taps[SYNC_STAGES-2:0], bor_req};
  end
  assign bor_load = bor_taps[SYNC_STAGES-1];
  assign bor_hold = |bor_taps;

  rstc_pin_filter #(.FILT_CYC(FILT_CYC), .SYNC_STAGES(SYNC_STAGES)) u_filt (
    .clk       (clk),
    .arst      (por_req),
    .pin_in    (pin_in),
    .self_drive(pin_drive_low),
    .pin_req   (pin_req)
  );

  assign tmr_load = bor_load | pin_req;

  rstc_pulse_timer #(.PULSE_CYC(PULSE_CYC), .CW(CW)) u_tmr (
    .clk (clk),
    .arst(por_req),
    .load(tmr_load),
    .cnt (tmr_cnt)
  );

  assign active        = (tmr_cnt != '0);
  assign pin_drive_low = active;

  // Asynchronous assertion by supply requests, synchronous release.
  assign out_arst = por_req | bor_req;

  rstc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rel (
    .clk (clk),
    .arst(out_arst),
    .d   (~(active | bor_hold)),
    .q   (sys_rst_n)
  );

  // Latest source wins; a request beats a clear in the same cycle.
  always_ff @(posedge clk or posedge por_req) begin
    if (por_req)        cause_q <= cause_t'(1 << CAUSE_POR);
    else if (bor_load)  cause_q <= cause_t'(1 << CAUSE_BOR);
    else if (pin_req)   cause_q <= cause_t'(1 << CAUSE_PIN);
    else if (cause_clr) cause_q <= CAUSE_NONE;
  end
  assign cause = cause_q;
endmodule

// File: rtl/reset_pulse_ctrl_chk.sv
module reset_pulse_ctrl_chk #(
  parameter int PULSE_CYC = 320,
  parameter int CW        = 9
) (
  input logic          clk,
  input logic          por_req,
  input logic          pin_drive_low,
  input logic          sys_rst_n,
  input logic [2:0]    cause,
  input logic          pin_req,
  input logic          load,
  input logic [CW-1:0] tmr_cnt
);
  // R1
  always @(negedge clk) begin
    if (por_req) begin
      a_r1_por_forces: assert (pin_drive_low && !sys_rst_n && cause == 3'b001);
    end
  end

  a_r5_reload_full: assert property (@(posedge clk) disable iff (por_req)
    load |=> (tmr_cnt == CW'(PULSE_CYC)));

  a_r4_req_single: assert property (@(posedge clk) disable iff (por_req)
    pin_req |=> !pin_req);

  a_r7_low_at_drop: assert property (@(posedge clk) disable iff (por_req)
    $fell(pin_drive_low) |-> !sys_rst_n);

  a_r8_cause_onehot: assert property (@(posedge clk) disable iff (por_req)
    $onehot0(cause));

  a_r9_no_self_trigger: assert property (@(posedge clk) disable iff (por_req)
    $fell(pin_drive_low) |=> !pin_req);
endmodule

bind reset_pulse_ctrl reset_pulse_ctrl_chk #(.PULSE_CYC(PULSE_CYC), .CW(CW)) u_chk (
  .clk          (clk),
  .por_req      (por_req),
  .pin_drive_low(pin_drive_low),
  .sys_rst_n    (sys_rst_n),
  .cause        (cause),
  .pin_req      (pin_req),
  .load         (tmr_load),
  .tmr_cnt      (tmr_cnt)
);

// File: tb/sim_reset_pulse_ctrl.sv
module sim_reset_pulse_ctrl;
  localparam int PULSE = 20;
  localparam int FILT  = 3;
  localparam int SYNC  = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       por_req   = 1'b1;
  logic       bor_req   = 1'b0;
  logic       ext_low   = 1'b0;
  logic       cause_clr = 1'b0;
  logic       pin_drive_low;
  logic       sys_rst_n;
  logic [2:0] cause;
  wire        pin_line = ~(ext_low | pin_drive_low);

  reset_pulse_ctrl #(.PULSE_CYC(PULSE), .FILT_CYC(FILT), .SYNC_STAGES(SYNC)) u0 (
    .clk          (clk),
    .por_req      (por_req),
    .bor_req      (bor_req),
    .pin_in       (pin_line),
    .cause_clr    (cause_clr),
    .pin_drive_low(pin_drive_low),
    .sys_rst_n    (sys_rst_n),
    .cause        (cause)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  int    exp_q[$];
  string tag_q[$];
  int    run    = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_run(input int len, input string req);
    exp_q.push_back(len);
    tag_q.push_back(req);
  endtask

  // Monitor: measure each drive-high run in negedge samples, compare to scoreboard.
  always @(negedge clk) begin
    if (pin_drive_low) run++;
    else if (run != 0) begin
      if (exp_q.size() == 0) chk(1'b0, "R9", run, 0);
      else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(run == e, t, run, e);
      end
      run = 0;
    end
  end

  task automatic wait_fall();
    do @(negedge clk); while (pin_drive_low);
  endtask

  task automatic quiet(input int n, input string req);
    int highs = 0;
    repeat (n) begin
      @(negedge clk);
      if (pin_drive_low) highs++;
    end
    chk(highs == 0, req, highs, 0);
  endtask

  task automatic clear_cause();
    @(negedge clk); #1 cause_clr = 1'b1;
    @(negedge clk); #1 cause_clr = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    // Power-on: held for 5 samples.
    repeat (5) @(negedge clk);
    chk(!sys_rst_n, "R1", sys_rst_n, 0);
    chk(pin_drive_low, "R1", pin_drive_low, 1);
    chk(cause == 3'b001, "R1", cause, 1);
    expect_run(5 + PULSE - 1, "R2");
    #1 por_req = 1'b0;
    wait_fall();
    chk(!sys_rst_n, "R7", sys_rst_n, 0);
    @(negedge clk); chk(!sys_rst_n, "R6", sys_rst_n, 0);
    @(negedge clk); chk(sys_rst_n, "R6", sys_rst_n, 1);
    chk(cause == 3'b001, "R8", cause, 1);
    @(negedge clk); #1 cause_clr = 1'b1;
    @(negedge clk); chk(cause == 3'b000, "R8", cause, 0);
    #1 cause_clr = 1'b0;
    repeat (5) @(negedge clk);

    // Brown-out from idle, one cycle wide.
    expect_run(PULSE, "R3");
    @(negedge clk); #1 bor_req = 1'b1;
    #1 chk(!sys_rst_n, "R3", sys_rst_n, 0);
    @(negedge clk); chk(!pin_drive_low, "R3", pin_drive_low, 0);
    #1 bor_req = 1'b0;
    @(negedge clk); chk(!pin_drive_low, "R3", pin_drive_low, 0);
    @(negedge clk); chk(pin_drive_low, "R3", pin_drive_low, 1);
    wait_fall();
    repeat (3) @(negedge clk);
    chk(cause == 3'b010, "R8", cause, 2);
    clear_cause();

    // Pin starts a pulse, brown-out restarts it mid-way.
    expect_run(28, "R5");
    @(negedge clk); #1 ext_low = 1'b1;
    repeat (6) @(negedge clk);
    chk(cause == 3'b100, "R8", cause, 4);
    #1 ext_low = 1'b0;
    repeat (4) @(negedge clk);
    #1 bor_req = 1'b1;
    @(negedge clk); #1 bor_req = 1'b0;
    wait_fall();
    repeat (2) @(negedge clk);
    chk(cause == 3'b010, "R5", cause, 2);
    quiet(20, "R9");
    clear_cause();

    // Pin low one cycle short of the threshold: ignored.
    @(negedge clk); #1 ext_low = 1'b1;
    repeat (FILT - 1) @(negedge clk);
    #1 ext_low = 1'b0;
    quiet(30, "R4");
    chk(cause == 3'b000, "R4", cause, 0);

    // Pin low exactly at the threshold: accepted.
    expect_run(PULSE, "R4");
    @(negedge clk); #1 ext_low = 1'b1;
    repeat (FILT) @(negedge clk);
    #1 ext_low = 1'b0;
    @(negedge clk); chk(!pin_drive_low, "R4", pin_drive_low, 0);
    @(negedge clk); chk(pin_drive_low, "R4", pin_drive_low, 1);
    wait_fall();
    chk(cause == 3'b100, "R8", cause, 4);
    quiet(20, "R9");

    // Request beats a clear in the same cycle.
    clear_cause();
    expect_run(PULSE, "R8");
    @(negedge clk); #1 begin cause_clr = 1'b1; bor_req = 1'b1; end
    @(negedge clk); #1 bor_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(cause == 3'b010, "R8", cause, 2);
    #1 cause_clr = 1'b0;
    wait_fall();
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R2", exp_q.size(), 0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R2", 0, 1);
      $display("watchdog expired");
      summary();
      $finish;
    end
  end
endmodule